// File: doc/BRIEF.md
# Vectored Interrupt Priority Tracker

This block holds the per-vector interrupt state of a local interrupt controller. It covers 256 vectors. Three bitmaps record which vectors are waiting for delivery, which are being serviced and which arrived level-triggered. An 8-bit task priority and a derived processor priority decide whether the highest waiting vector may interrupt the current work. Requests arrive with a vector and a trigger mode. The core takes a vector through an acknowledge handshake and retires it with an end-of-interrupt strobe. When a level-triggered vector is retired, a one-cycle pulse carries that vector upstream so the source can re-sample its line.

Each bitmap is searched for its highest set bit by a word-serial scanner. The scanner reads one 32-bit word per cycle, starting from the top word. After any change to the priority-relevant state, the block lowers `ready` until a fresh search has finished. Acknowledge and end-of-interrupt are taken only while `ready` is high. Requests and task-priority writes are taken in any cycle.

Top module: `vec_prio_tracker`

## Requirements
- R1: After reset all three bitmaps and the task priority are zero, `ppr` reads 0, `intr_avail` is low, `ready` is high, and an acknowledge returns `ack_hit` = 0.
- R2: A request for a vector whose pending bit is clear is reported with `req_acc` = 1 one cycle later (`req_done` = 1). A request for a vector that is already pending is reported with `req_acc` = 0.
- R3: On an accepted request, the trigger bit of the vector is set when `req_level` = 1 and cleared when `req_level` = 0. A repeated request for a pending vector leaves the trigger bit unchanged when it is level-triggered. It overwrites the trigger bit with edge (clear) when it is edge-triggered.
- R4: A request is dropped (`req_acc` = 0, nothing becomes pending) while `glb_en` or `sw_en` is low. While either enable is low, acknowledge returns no vector.
- R5: Vectors 0 to 15 are reserved. A request for one of them is dropped, and an acknowledged vector is always 16 or above.
- R6: `ppr` equals the full task priority when the task priority's upper nibble is greater than or equal to the upper nibble of the highest in-service vector. Otherwise `ppr` equals that vector with its low nibble cleared. An empty in-service map counts as vector 0.
- R7: A vector can be delivered (`intr_avail` = 1, `ack_hit` = 1) only when the highest pending vector, with its low nibble cleared, is strictly greater than `ppr`. An acknowledge that finds nothing deliverable returns `ack_hit` = 0 and changes no state.
- R8: A successful acknowledge returns the highest pending vector on `ack_vec`. It moves that vector from pending to in service, so `ppr` rises to the vector's class.
- R9: End of interrupt clears the highest in-service vector. If that vector's trigger bit was set, the bit is cleared and `leoi_valid` pulses for one cycle with the vector on `leoi_vec`. With an empty in-service map the strobe does nothing.
- R10: After any state change, `ready` stays low for exactly NWORD+1 = 9 cycles. An acknowledge or end-of-interrupt strobe presented while `ready` is low is ignored. When both are presented in a ready cycle, end of interrupt is taken and the acknowledge waits.
- R11: The highest-bit search picks the highest set vector across all words, whatever word boundaries lie between the set vectors.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released through a two-stage synchronizer |
| glb_en | input | 1 | Global controller enable |
| sw_en | input | 1 | Software controller enable |
| req_valid | input | 1 | Interrupt request strobe |
| req_vector | input | 8 | Requested vector |
| req_level | input | 1 | 1 = level-triggered, 0 = edge-triggered |
| req_done | output | 1 | Request result valid (one cycle after the request) |
| req_acc | output | 1 | Request was accepted as newly pending |
| tpr_we | input | 1 | Task priority write strobe |
| tpr_wdata | input | 8 | Task priority write value |
| ack_req | input | 1 | Acknowledge request (taken when `ready`) |
| eoi_req | input | 1 | End-of-interrupt strobe (taken when `ready`) |
| ready | output | 1 | Search results current; acknowledge and EOI may be taken |
| intr_avail | output | 1 | A deliverable vector is pending (valid while `ready`) |
| ppr | output | 8 | Processor priority (valid while `ready`) |
| ack_done | output | 1 | Acknowledge result valid |
| ack_hit | output | 1 | Acknowledge delivered a vector |
| ack_vec | output | 8 | Delivered vector |
| leoi_valid | output | 1 | Level-triggered end-of-interrupt pulse |
| leoi_vec | output | 8 | Vector retired by the level-triggered end of interrupt |

## Verification
A bad bitmap bit is not visible directly. It appears as a wrong vector on the next acknowledge, as a wrong `ppr` class once `ready` returns, or as a missing or extra level end-of-interrupt pulse when that vector is retired. A wrong trigger bit shows only at retirement. For that reason the tests drive each vector through its full request, acknowledge and retire sequence. A fault in the scanner or in the busy tracking shows within one search window of nine cycles, either as a wrong `ready` duration or as stale priority results.

// File: rtl/vpt_pkg.sv
package vpt_pkg;
  localparam int VEC_W   = 8;
  localparam int CLASS_W = 4;

  typedef logic [VEC_W-1:0] vec_t;

  function automatic vec_t class_floor(input vec_t v);
    return {v[VEC_W-1:CLASS_W], {CLASS_W{1'b0}}};
  endfunction
endpackage

// File: rtl/vpt_word_scan.sv
module vpt_word_scan #(
  parameter int WORD_W = 32,
  localparam int BIW = $clog2(WORD_W)
) (
  input  logic [WORD_W-1:0] word,
  output logic              any,
  output logic [BIW-1:0]    top
);
  always_comb begin
    any = 1'b0;
    top = '0;
    for (int i = 0; i < WORD_W; i++) begin
      if (word[i]) begin
        any = 1'b1;
        top = i[BIW-1:0];
      end
    end
  end
endmodule

// File: rtl/vpt_scanner.sv
module vpt_scanner #(
  parameter int NVEC   = 256,
  parameter int WORD_W = 32,
  localparam int VW    = $clog2(NVEC),
  localparam int NWORD = NVEC / WORD_W,
  localparam int WIW   = $clog2(NWORD),
  localparam int BIW   = $clog2(WORD_W),
  localparam int NMAP  = 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            start,
  input  logic [NVEC-1:0] irr_map,
  input  logic [NVEC-1:0] isr_map,
  output logic            active,
  output logic            irr_found,
  output logic [VW-1:0]   irr_top,
  output logic            isr_found,
  output logic [VW-1:0]   isr_top
);
  logic [NVEC-1:0] maps [NMAP];
  logic [VW-1:0]   base;
  logic [NMAP-1:0] w_any;
  logic [BIW-1:0]  w_top [NMAP];

  logic            act_q, act_n;
  logic [WIW-1:0]  widx_q, widx_n;
  logic [NMAP-1:0] fnd_q, fnd_n;
  logic [VW-1:0]   cand_q [NMAP];
  logic [VW-1:0]   cand_n [NMAP];
  logic [NMAP-1:0] res_v_q, res_v_n;
  logic [VW-1:0]   res_q [NMAP];
  logic [VW-1:0]   res_n [NMAP];

  assign maps[0] = irr_map;
  assign maps[1] = isr_map;
  assign base    = {widx_q, {BIW{1'b0}}};

  for (genvar m = 0; m < NMAP; m++) begin : g_map
    vpt_word_scan #(.WORD_W(WORD_W)) u_ws (
      .word (maps[m][base +: WORD_W]),
      .any  (w_any[m]),
      .top  (w_top[m])
    );
  end

  always_comb begin
    act_n   = act_q;
    widx_n  = widx_q;
    fnd_n   = fnd_q;
    res_v_n = res_v_q;
    for (int m = 0; m < NMAP; m++) begin
      cand_n[m] = cand_q[m];
      res_n[m]  = res_q[m];
    end
    if (start && !act_q) begin
      act_n  = 1'b1;
      widx_n = WIW'(NWORD - 1);
      fnd_n  = '0;
    end else if (act_q) begin
      for (int m = 0; m < NMAP; m++) begin
        if (!fnd_q[m] && w_any[m]) begin
          fnd_n[m]  = 1'b1;
          cand_n[m] = {widx_q, w_top[m]};
        end
      end
      if (widx_q == '0) begin
        act_n = 1'b0;
        for (int m = 0; m < NMAP; m++) begin
          res_v_n[m] = fnd_n[m];
          res_n[m]   = fnd_n[m] ? cand_n[m] : '0;
        end
      end else begin
        widx_n = widx_q - 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_q   <= 1'b0;
      widx_q  <= '0;
      fnd_q   <= '0;
      res_v_q <= '0;
      for (int m = 0; m < NMAP; m++) begin
        cand_q[m] <= '0;
        res_q[m]  <= '0;
      end
    end else begin
      act_q   <= act_n;
      widx_q  <= widx_n;
      fnd_q   <= fnd_n;
      res_v_q <= res_v_n;
      for (int m = 0; m < NMAP; m++) begin
        cand_q[m] <= cand_n[m];
        res_q[m]  <= res_n[m];
      end
    end
  end

  assign active    = act_q;
  assign irr_found = res_v_q[0];
  assign irr_top   = res_q[0];
  assign isr_found = res_v_q[1];
  assign isr_top   = res_q[1];
endmodule

// File: rtl/vpt_prio.sv
module vpt_prio
  import vpt_pkg::*;
(
  input  logic  enabled,
  input  vec_t  tpr,
  input  logic  isr_found,
  input  vec_t  isr_top,
  input  logic  irr_found,
  input  vec_t  irr_top,
  output vec_t  ppr,
  output logic  deliver
);
  vec_t isr_eff;

  always_comb begin
    isr_eff = isr_found ? isr_top : '0;
    if (tpr[VEC_W-1:CLASS_W] >= isr_eff[VEC_W-1:CLASS_W])
      ppr = tpr;
    else
      ppr = class_floor(isr_eff);
    deliver = enabled && irr_found && (class_floor(irr_top) > ppr);
  end
endmodule

// File: rtl/vec_prio_tracker.sv
module vec_prio_tracker
  import vpt_pkg::*;
#(
  parameter int NVEC    = 256,
  parameter int WORD_W  = 32,
  parameter int RSV_VEC = 16,
  localparam int VW     = $clog2(NVEC)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          glb_en,
  input  logic          sw_en,
  input  logic          req_valid,
  input  logic [VW-1:0] req_vector,
  input  logic          req_level,
  output logic          req_done,
  output logic          req_acc,
  input  logic          tpr_we,
  input  logic [VW-1:0] tpr_wdata,
  input  logic          ack_req,
  input  logic          eoi_req,
  output logic          ready,
  output logic          intr_avail,
  output logic [VW-1:0] ppr,
  output logic          ack_done,
  output logic          ack_hit,
  output logic [VW-1:0] ack_vec,
  output logic          leoi_valid,
  output logic [VW-1:0] leoi_vec
);
  // reset synchronizer: asynchronous assert, synchronous release
  logic [1:0] rst_sync_q;
  logic       rst_int_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  // state
  logic [NVEC-1:0] irr_q, irr_n;
  logic [NVEC-1:0] isr_q, isr_n;
  logic [NVEC-1:0] tmr_q, tmr_n;
  logic [VW-1:0]   tpr_q, tpr_n;
  logic            dirty_q, dirty_n;

  logic            req_done_q, req_done_n, req_acc_q, req_acc_n;
  logic            ack_done_q, ack_done_n, ack_hit_q, ack_hit_n;
  logic [VW-1:0]   ack_vec_q, ack_vec_n;
  logic            leoi_v_q, leoi_v_n;
  logic [VW-1:0]   leoi_vec_q, leoi_vec_n;

  // search results
  logic            scan_act;
  logic            irr_found, isr_found;
  logic [VW-1:0]   irr_top, isr_top;
  logic [VW-1:0]   ppr_c;
  logic            deliver;

  logic            enabled;
  logic            take_eoi, take_ack, ack_fire, eoi_fire;
  logic            req_ok, req_old, req_new, req_tmr_upd;
  logic            state_chg, map_en, out_en;
  logic            scan_start;

  assign enabled    = glb_en & sw_en;
  assign ready      = ~dirty_q & ~scan_act;
  assign scan_start = dirty_q & ~scan_act;

  vpt_scanner #(.NVEC(NVEC), .WORD_W(WORD_W)) u_scan (
    .clk       (clk),
    .rst_n     (rst_int_n),
    .start     (scan_start),
    .irr_map   (irr_q),
    .isr_map   (isr_q),
    .active    (scan_act),
    .irr_found (irr_found),
    .irr_top   (irr_top),
    .isr_found (isr_found),
    .isr_top   (isr_top)
  );

  vpt_prio u_prio (
    .enabled   (enabled),
    .tpr       (tpr_q),
    .isr_found (isr_found),
    .isr_top   (isr_top),
    .irr_found (irr_found),
    .irr_top   (irr_top),
    .ppr       (ppr_c),
    .deliver   (deliver)
  );

  // handshake decode
  assign take_eoi = eoi_req & ready;
  assign take_ack = ack_req & ready & ~eoi_req;
  assign ack_fire = take_ack & deliver;
  assign eoi_fire = take_eoi & isr_found;

  // request decode
  assign req_ok      = req_valid & enabled & (req_vector >= VW'(RSV_VEC));
  assign req_old     = irr_q[req_vector];
  assign req_new     = req_ok & ~req_old;
  assign req_tmr_upd = req_ok & ~(req_old & req_level);

  assign state_chg = ack_fire | eoi_fire | req_new | tpr_we;
  assign map_en    = ack_fire | eoi_fire | req_ok;
  assign out_en    = req_valid | take_ack | take_eoi | req_done_q | ack_done_q | leoi_v_q;

  // next-state: bitmaps and priority
  always_comb begin
    irr_n = irr_q;
    isr_n = isr_q;
    tmr_n = tmr_q;
    if (ack_fire) begin
      isr_n[irr_top] = 1'b1;
      irr_n[irr_top] = 1'b0;
    end
    if (eoi_fire) begin
      isr_n[isr_top] = 1'b0;
      if (tmr_q[isr_top]) tmr_n[isr_top] = 1'b0;
    end
    if (req_new) irr_n[req_vector] = 1'b1;
    if (req_tmr_upd) tmr_n[req_vector] = req_level;
  end

  always_comb begin
    tpr_n = tpr_we ? tpr_wdata : tpr_q;
    if (state_chg)       dirty_n = 1'b1;
    else if (scan_start) dirty_n = 1'b0;
    else                 dirty_n = dirty_q;
  end

  // next-state: response outputs
  always_comb begin
    req_done_n = req_valid;
    req_acc_n  = req_new;
    ack_done_n = take_ack;
    ack_hit_n  = ack_fire;
    ack_vec_n  = ack_fire ? irr_top : '0;
    leoi_v_n   = eoi_fire & tmr_q[isr_top];
    leoi_vec_n = (eoi_fire & tmr_q[isr_top]) ? isr_top : '0;
  end

  // registers
  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      irr_q <= '0;
      isr_q <= '0;
      tmr_q <= '0;
    end else if (map_en) begin
      irr_q <= irr_n;
      isr_q <= isr_n;
      tmr_q <= tmr_n;
    end
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      tpr_q   <= '0;
      dirty_q <= 1'b0;
    end else begin
      if (tpr_we) tpr_q <= tpr_n;
      dirty_q <= dirty_n;
    end
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      req_done_q <= 1'b0;
      req_acc_q  <= 1'b0;
      ack_done_q <= 1'b0;
      ack_hit_q  <= 1'b0;
      ack_vec_q  <= '0;
      leoi_v_q   <= 1'b0;
      leoi_vec_q <= '0;
    end else if (out_en) begin
      req_done_q <= req_done_n;
      req_acc_q  <= req_acc_n;
      ack_done_q <= ack_done_n;
      ack_hit_q  <= ack_hit_n;
      ack_vec_q  <= ack_vec_n;
      leoi_v_q   <= leoi_v_n;
      leoi_vec_q <= leoi_vec_n;
    end
  end

  assign req_done   = req_done_q;
  assign req_acc    = req_acc_q;
  assign ack_done   = ack_done_q;
  assign ack_hit    = ack_hit_q;
  assign ack_vec    = ack_vec_q;
  assign leoi_valid = leoi_v_q;
  assign leoi_vec   = leoi_vec_q;
  assign ppr        = ppr_c;
  assign intr_avail = deliver;
endmodule

// File: rtl/vpt_checker.sv
module vpt_checker (
  input logic       clk,
  input logic       rst_n,
  input logic       glb_en,
  input logic       sw_en,
  input logic       req_valid,
  input logic [7:0] req_vector,
  input logic       req_level,
  input logic       req_done,
  input logic       req_acc,
  input logic       tpr_we,
  input logic [7:0] tpr_wdata,
  input logic       ack_req,
  input logic       eoi_req,
  input logic       ready,
  input logic       intr_avail,
  input logic [7:0] ppr,
  input logic       ack_done,
  input logic       ack_hit,
  input logic [7:0] ack_vec,
  input logic       leoi_valid,
  input logic [7:0] leoi_vec
);
  // R10: acknowledge answered only for a request taken in a ready cycle
  assert_ack_taken_ready_R10: assert property (@(posedge clk) disable iff (!rst_n)
    ack_done |-> $past(ack_req && ready && !eoi_req));

  // R10: a delivered vector changes state, so the next cycle is busy
  assert_busy_after_ack_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_done && ack_hit) |=> !ready);

  // R9: level EOI pulse only follows an EOI taken in a ready cycle
  assert_leoi_after_eoi_R9: assert property (@(posedge clk) disable iff (!rst_n)
    leoi_valid |-> $past(eoi_req && ready));

  // R9: the pulse lasts one cycle
  assert_leoi_single_R9: assert property (@(posedge clk) disable iff (!rst_n)
    leoi_valid |=> !leoi_valid);

  // R7: a delivered vector's class exceeds the priority seen when taken
  assert_ack_above_ppr_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_done && ack_hit) |-> (ack_vec[7:4] > $past(ppr[7:4])));

  // R5: reserved vectors are never delivered
  assert_ack_not_reserved_R5: assert property (@(posedge clk) disable iff (!rst_n)
    ack_hit |-> (ack_vec >= 8'd16));

  // R2: a request result follows a request
  assert_req_result_R2: assert property (@(posedge clk) disable iff (!rst_n)
    req_done |-> $past(req_valid));

  // R4: acceptance requires both enables
  assert_req_enabled_R4: assert property (@(posedge clk) disable iff (!rst_n)
    req_acc |-> ($past(glb_en && sw_en) && req_done));
endmodule

bind vec_prio_tracker vpt_checker u_vpt_checker (.*);

// File: tb/vec_prio_tracker_test.sv
module vec_prio_tracker_test;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       glb_en, sw_en;
  logic       req_valid;
  logic [7:0] req_vector;
  logic       req_level;
  logic       req_done, req_acc;
  logic       tpr_we;
  logic [7:0] tpr_wdata;
  logic       ack_req, eoi_req;
  logic       ready, intr_avail;
  logic [7:0] ppr;
  logic       ack_done, ack_hit;
  logic [7:0] ack_vec;
  logic       leoi_valid;
  logic [7:0] leoi_vec;

  int checks = 0;
  int errors = 0;
  int cyc    = 0;

  always #4 clk = ~clk;

  vec_prio_tracker uut (.*);

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 100000) begin
      errors = errors + 1;
      $display("FAIL watchdog R10: actual cycles %0d expected < 100000", cyc);
      $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  task automatic chk(input bit ok, input string rq, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", rq, act, exp);
    end
  endtask

  task automatic wait_ready();
    while (!ready) @(negedge clk);
  endtask

  task automatic do_req(input logic [7:0] v, input logic lvl, output logic acc);
    req_valid = 1'b1; req_vector = v; req_level = lvl;
    @(negedge clk);
    req_valid = 1'b0;
    chk(req_done == 1'b1, "R2 req_done", req_done, 1);
    acc = req_acc;
  endtask

  task automatic do_ack(output logic hit, output logic [7:0] v);
    wait_ready();
    ack_req = 1'b1;
    @(negedge clk);
    ack_req = 1'b0;
    chk(ack_done == 1'b1, "R10 ack_done", ack_done, 1);
    hit = ack_hit; v = ack_vec;
    wait_ready();
  endtask

  task automatic do_eoi(output logic lv, output logic [7:0] v);
    wait_ready();
    eoi_req = 1'b1;
    @(negedge clk);
    eoi_req = 1'b0;
    lv = leoi_valid; v = leoi_vec;
    wait_ready();
  endtask

  task automatic do_tpr(input logic [7:0] v);
    tpr_we = 1'b1; tpr_wdata = v;
    @(negedge clk);
    tpr_we = 1'b0;
    wait_ready();
  endtask

  task automatic t_reset();
    logic h; logic [7:0] v;
    chk(ready == 1'b1, "R1 ready", ready, 1);
    chk(ppr == 8'h00, "R1 ppr", ppr, 0);
    chk(intr_avail == 1'b0, "R1 intr_avail", intr_avail, 0);
    do_ack(h, v);
    chk(h == 1'b0, "R1 ack empty", h, 0);
  endtask

  task automatic t_accept();
    logic a, h, lv; logic [7:0] v; int n;
    do_req(8'h41, 1'b0, a);
    chk(a == 1'b1, "R2 new accept", a, 1);
    n = 0;
    while (!ready) begin n++; @(negedge clk); end
    chk(n == 9, "R10 busy cycles", n, 9);
    do_req(8'h41, 1'b0, a);
    chk(a == 1'b0, "R2 repeat rejected", a, 0);
    wait_ready();
    chk(intr_avail == 1'b1, "R7 avail", intr_avail, 1);
    do_ack(h, v);
    chk(h && v == 8'h41, "R8 ack vec", v, 8'h41);
    chk(ppr == 8'h40, "R8 ppr class", ppr, 8'h40);
    do_eoi(lv, v);
    chk(lv == 1'b0, "R9 edge no pulse", lv, 0);
    chk(ppr == 8'h00, "R9 ppr after eoi", ppr, 0);
  endtask

  task automatic t_level();
    logic a, h, lv; logic [7:0] v;
    do_req(8'h52, 1'b1, a);
    do_ack(h, v);
    chk(h && v == 8'h52, "R8 ack level vec", v, 8'h52);
    do_eoi(lv, v);
    chk(lv == 1'b1, "R9 level pulse", lv, 1);
    chk(v == 8'h52, "R9 level vec", v, 8'h52);
    @(negedge clk);
    chk(leoi_valid == 1'b0, "R9 pulse one cycle", leoi_valid, 0);
  endtask

  task automatic t_repeat_modes();
    logic a, h, lv; logic [7:0] v;
    do_req(8'h63, 1'b1, a);
    do_req(8'h63, 1'b0, a);
    chk(a == 1'b0, "R3 repeat edge rejected", a, 0);
    do_ack(h, v);
    do_eoi(lv, v);
    chk(lv == 1'b0, "R3 repeat edge clears trigger", lv, 0);
    do_req(8'h74, 1'b0, a);
    do_req(8'h74, 1'b1, a);
    chk(a == 1'b0, "R3 repeat level rejected", a, 0);
    do_ack(h, v);
    do_eoi(lv, v);
    chk(lv == 1'b0, "R3 repeat level keeps edge", lv, 0);
    do_req(8'h75, 1'b1, a);
    do_req(8'h75, 1'b1, a);
    do_ack(h, v);
    do_eoi(lv, v);
    chk(lv == 1'b1 && v == 8'h75, "R3 level kept", v, 8'h75);
  endtask

  task automatic t_disabled();
    logic a, h; logic [7:0] v;
    glb_en = 1'b0;
    do_req(8'h80, 1'b0, a);
    chk(a == 1'b0, "R4 global off drop", a, 0);
    glb_en = 1'b1; sw_en = 1'b0;
    do_req(8'h81, 1'b0, a);
    chk(a == 1'b0, "R4 sw off drop", a, 0);
    sw_en = 1'b1;
    wait_ready();
    chk(intr_avail == 1'b0, "R4 nothing pending", intr_avail, 0);
    do_req(8'h82, 1'b0, a);
    wait_ready();
    sw_en = 1'b0;
    do_ack(h, v);
    chk(h == 1'b0, "R4 no delivery while off", h, 0);
    sw_en = 1'b1;
    do_ack(h, v);
    chk(h && v == 8'h82, "R4 delivery after enable", v, 8'h82);
    do_eoi(a, v);
  endtask

  task automatic t_reserved();
    logic a;
    do_req(8'h0F, 1'b0, a);
    chk(a == 1'b0, "R5 reserved dropped", a, 0);
    wait_ready();
    chk(intr_avail == 1'b0, "R5 nothing pending", intr_avail, 0);
  endtask

  task automatic t_highest();
    logic a, h, lv; logic [7:0] v;
    do_req(8'h25, 1'b0, a);
    do_req(8'hE1, 1'b0, a);
    do_req(8'h9A, 1'b0, a);
    do_ack(h, v);
    chk(h && v == 8'hE1, "R11 top word", v, 8'hE1);
    chk(ppr == 8'hE0, "R6 ppr isr class", ppr, 8'hE0);
    chk(intr_avail == 1'b0, "R7 lower class blocked", intr_avail, 0);
    do_ack(h, v);
    chk(h == 1'b0, "R7 blocked ack empty", h, 0);
    do_eoi(lv, v);
    do_ack(h, v);
    chk(h && v == 8'h9A, "R11 next word", v, 8'h9A);
    do_ack(h, v);
    chk(h == 1'b0, "R7 nested blocked", h, 0);
    do_eoi(lv, v);
    do_ack(h, v);
    chk(h && v == 8'h25, "R11 low word", v, 8'h25);
    do_eoi(lv, v);
    chk(ppr == 8'h00, "R6 empty isr", ppr, 0);
  endtask

  task automatic t_tpr();
    logic a, h, lv; logic [7:0] v;
    do_tpr(8'h35);
    do_req(8'h38, 1'b0, a);
    wait_ready();
    chk(ppr == 8'h35, "R6 ppr equals tpr", ppr, 8'h35);
    chk(intr_avail == 1'b0, "R7 equal class blocked", intr_avail, 0);
    do_tpr(8'h2F);
    chk(intr_avail == 1'b1, "R7 class above ppr", intr_avail, 1);
    do_ack(h, v);
    chk(h && v == 8'h38, "R8 ack under tpr", v, 8'h38);
    chk(ppr == 8'h30, "R6 isr class wins", ppr, 8'h30);
    do_tpr(8'h47);
    chk(ppr == 8'h47, "R6 tpr wins", ppr, 8'h47);
    do_tpr(8'h3A);
    chk(ppr == 8'h3A, "R6 equal class uses tpr", ppr, 8'h3A);
    do_eoi(lv, v);
    chk(ppr == 8'h3A, "R6 after eoi", ppr, 8'h3A);
    do_tpr(8'h00);
  endtask

  task automatic t_eoi_empty();
    logic lv; logic [7:0] v;
    do_eoi(lv, v);
    chk(lv == 1'b0, "R9 empty eoi no pulse", lv, 0);
    chk(ready == 1'b1, "R9 empty eoi no change", ready, 1);
  endtask

  task automatic t_stall();
    logic a, h, lv; logic [7:0] v;
    do_req(8'hB0, 1'b1, a);
    do_ack(h, v);
    do_req(8'hC0, 1'b0, a);
    chk(ready == 1'b0, "R10 busy after request", ready, 0);
    eoi_req = 1'b1;
    @(negedge clk);
    eoi_req = 1'b0;
    chk(leoi_valid == 1'b0, "R10 eoi ignored", leoi_valid, 0);
    wait_ready();
    chk(ppr == 8'hB0, "R10 isr intact", ppr, 8'hB0);
    do_ack(h, v);
    chk(h && v == 8'hC0, "R8 nested ack", v, 8'hC0);
    eoi_req = 1'b1; ack_req = 1'b1;
    @(negedge clk);
    eoi_req = 1'b0; ack_req = 1'b0;
    chk(ack_done == 1'b0, "R10 eoi wins over ack", ack_done, 0);
    chk(leoi_valid == 1'b0, "R9 edge retired", leoi_valid, 0);
    do_eoi(lv, v);
    chk(lv == 1'b1 && v == 8'hB0, "R9 level retired", v, 8'hB0);
  endtask

  initial begin
    rst_n = 1'b0; glb_en = 1'b1; sw_en = 1'b1;
    req_valid = 1'b0; req_vector = '0; req_level = 1'b0;
    tpr_we = 1'b0; tpr_wdata = '0; ack_req = 1'b0; eoi_req = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    t_reset();
    t_accept();
    t_level();
    t_repeat_modes();
    t_disabled();
    t_reserved();
    t_highest();
    t_tpr();
    t_eoi_empty();
    t_stall();
    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule